// File: doc/BRIEF.md
# PLL Power-Up Sequencing Controller

This controller drives the three control lines of a PLL and its mode register image. An enable request brings the PLL up in three steps. First it releases bypass. After a fixed settling delay it deasserts the active-low reset. After a fixed lock delay it turns on the output. A disable request drops all three lines together. Both delays are counted in clock cycles. Each is a microsecond figure multiplied by a cycles-per-microsecond parameter: 10 us for bypass settling and 50 us for lock. The analog PLL is outside the block, and lock is modelled only as the timed wait.

A hardware-vote mode can also be entered, after which an external voting machine owns the PLL. Entry runs its own ordered sequence. It clears the vote-machine reset bit, then writes the bias and lock count fields, then sets the vote-enable bit. While vote-enable is set, direct enable and disable requests are discarded. Requests that arrive while a sequence is running are held, and they are acted on when the controller next comes to rest.

The state machine has seven states:
- `S_OFF` and `S_ON` are the two rest states.
- `S_BYP` is the bypass-settling wait. `S_LOCK` is the lock wait.
- `S_V_CLR`, `S_V_CNT` and `S_V_SET` are the three vote-entry steps.

The transitions are:
- `S_OFF`→`S_BYP` on a pending enable.
- `S_BYP`→`S_LOCK` and `S_LOCK`→`S_ON` when the timer expires.
- `S_ON`→`S_OFF` on a pending disable.
- `S_OFF`/`S_ON`→`S_V_CLR` on a pending vote entry, then `S_V_CLR`→`S_V_CNT`→`S_V_SET`.
- `S_V_SET` returns to `S_ON` if the output is on, and to `S_OFF` otherwise.

Each state's action is applied on the edge that enters it.

Top module: `pll_seq_ctrl`

## Requirements
- R1: A synchronous reset clears all three control lines and `done`. The register image then reads: bit 21 (vote-machine reset) = 1, bit 20 (vote enable) = 0, lock count field = `LOCK_INIT`, bias count field = `BIAS_INIT`, and all other bits 0.
- R2: Power-up order is bypass release (image bit 1), then reset deassert (bit 2, active low), then output enable (bit 0). A later line is never high while an earlier one is low.
- R3: Reset deassert follows bypass release by exactly `CYC_PER_US*BYP_US` cycles.
- R4: Output enable follows reset deassert by exactly `CYC_PER_US*LOCK_US` cycles, and `done` rises on the same edge as output enable.
- R5: An enable request while all three lines are already set changes nothing and does not restart the sequence.
- R6: A disable request clears all three lines on one edge and drops `done`.
- R7: A request that arrives during a sequence is held until the sequence completes. The most recent request wins. A disable and an enable in the same cycle count as a disable.
- R8: Vote entry updates the image on three consecutive edges, in this order:
  1. bit 21 clears;
  2. the bias count (bits 19:14) becomes 1 and the lock count (bits 13:8) becomes 0;
  3. bit 20 sets.
- R9: While bit 20 is set, enable and disable requests leave the control lines unchanged, and bit 20 stays set until reset.
- R10: A request sampled on clock edge k causes its first control-line change on edge k+1 after it (two edges from the cycle it is driven).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| vote_req | input | 1 | Enter hardware-vote mode |
| pll_outen | output | 1 | PLL output enable |
| pll_bypass_rel | output | 1 | Bypass release, active high |
| pll_reset_n | output | 1 | PLL reset, active low |
| mode_word | output | 22 | Register image of control and vote fields |
| done | output | 1 | Output enabled and sequence complete |

## Verification
The bench measures the gap between each pair of control-line edges in every sequence, including those started by random traffic. A controller that shortened or merged a wait would show a wrong cycle count. A controller that changed the order would break the edge ordering. Requests are issued mid-sequence and with enable and disable in the same cycle. A controller that aborted a running sequence, dropped a held request or broke the tie the wrong way would end in the wrong rest state. Vote entry is sampled on each of its three edges to catch reordered field updates. Requests issued in vote mode, starting from both rest states, would expose a controller that still obeyed them.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_BYP,
        S_LOCK,
        S_ON,
        S_V_CLR,
        S_V_CNT,
        S_V_SET
    } seq_state_e;

    localparam int unsigned IMG_W    = 22;
    localparam int unsigned CNT_W    = 6;
    localparam int unsigned LOCK_LSB = 8;
    localparam int unsigned BIAS_LSB = 14;
    localparam int unsigned VOTE_BIT = 20;
    localparam int unsigned VRST_BIT = 21;

    // control line indices inside the 3-bit control vector
    localparam int unsigned C_OUTEN  = 0;
    localparam int unsigned C_BYPASS = 1;
    localparam int unsigned C_RSTN   = 2;

    function automatic logic [IMG_W-1:0] pack_image(
        input logic [2:0]       ctrl,
        input logic [CNT_W-1:0] lock_cnt,
        input logic [CNT_W-1:0] bias_cnt,
        input logic             vote,
        input logic             vrst
    );
        logic [IMG_W-1:0] w;
        w = '0;
        w[2:0] = ctrl;
        w[LOCK_LSB +: CNT_W] = lock_cnt;
        w[BIAS_LSB +: CNT_W] = bias_cnt;
        w[VOTE_BIT] = vote;
        w[VRST_BIT] = vrst;
        return w;
    endfunction

endpackage

// File: rtl/pll_seq_req.sv
module pll_seq_req (
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    input  logic dis_req,
    input  logic vote_req,
    input  logic vote_active,
    input  logic take_en,
    input  logic take_dis,
    input  logic take_vote,
    output logic en_pend,
    output logic dis_pend,
    output logic vote_pend
);

    // Held request flags; the newest direct request replaces the other.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_pend   <= 1'b0;
            dis_pend  <= 1'b0;
            vote_pend <= 1'b0;
        end else if (vote_active) begin
            en_pend   <= 1'b0;
            dis_pend  <= 1'b0;
            vote_pend <= 1'b0;
        end else begin
            if (dis_req) begin
                dis_pend <= 1'b1;
                en_pend  <= 1'b0;
            end else if (en_req) begin
                en_pend  <= 1'b1;
                dis_pend <= 1'b0;
            end else begin
                if (take_en)  en_pend  <= 1'b0;
                if (take_dis) dis_pend <= 1'b0;
            end
            if (vote_req)       vote_pend <= 1'b1;
            else if (take_vote) vote_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int unsigned BYP_CYC   = 1000,
    parameter int unsigned LOCK_CYC  = 5000,
    parameter int unsigned TW        = 13,
    parameter logic [5:0]  LOCK_INIT = 6'd16,
    parameter logic [5:0]  BIAS_INIT = 6'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_pend,
    input  logic              dis_pend,
    input  logic              vote_pend,
    input  logic              tmr_expired,
    output logic              take_en,
    output logic              take_dis,
    output logic              take_vote,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    output logic [2:0]        ctrl,
    output logic              done,
    output logic [CNT_W-1:0]  lock_cnt,
    output logic [CNT_W-1:0]  bias_cnt,
    output logic              vote_on,
    output logic              vrst
);

    localparam logic [TW-1:0] BYP_LOAD  = TW'(BYP_CYC - 1);
    localparam logic [TW-1:0] LOCK_LOAD = TW'(LOCK_CYC - 1);

    seq_state_e state, nxt;

    // next-state and request acceptance
    always_comb begin
        nxt       = state;
        take_en   = 1'b0;
        take_dis  = 1'b0;
        take_vote = 1'b0;
        unique case (state)
            S_OFF: begin
                if (vote_pend && !vote_on) begin
                    take_vote = 1'b1;
                    nxt       = S_V_CLR;
                end else if (dis_pend) begin
                    take_dis = 1'b1;
                end else if (en_pend) begin
                    take_en = 1'b1;
                    nxt     = S_BYP;
                end
            end
            S_ON: begin
                if (vote_pend && !vote_on) begin
                    take_vote = 1'b1;
                    nxt       = S_V_CLR;
                end else if (dis_pend) begin
                    take_dis = 1'b1;
                    nxt      = S_OFF;
                end else if (en_pend) begin
                    take_en = 1'b1;
                end
            end
            S_BYP:   if (tmr_expired) nxt = S_LOCK;
            S_LOCK:  if (tmr_expired) nxt = S_ON;
            S_V_CLR: nxt = S_V_CNT;
            S_V_CNT: nxt = S_V_SET;
            S_V_SET: nxt = done ? S_ON : S_OFF;
            default: nxt = S_OFF;
        endcase
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (nxt != state) begin
            if (nxt == S_BYP) begin
                tmr_load = 1'b1;
                tmr_val  = BYP_LOAD;
            end else if (nxt == S_LOCK) begin
                tmr_load = 1'b1;
                tmr_val  = LOCK_LOAD;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_OFF;
        else     state <= nxt;
    end

    // outputs: each state's action is applied on entry
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= 3'b000;
            done     <= 1'b0;
            lock_cnt <= LOCK_INIT;
            bias_cnt <= BIAS_INIT;
            vote_on  <= 1'b0;
            vrst     <= 1'b1;
        end else if (nxt != state) begin
            unique case (nxt)
                S_BYP:   ctrl[C_BYPASS] <= 1'b1;
                S_LOCK:  ctrl[C_RSTN]   <= 1'b1;
                S_ON: begin
                    ctrl[C_OUTEN] <= 1'b1;
                    done          <= 1'b1;
                end
                S_OFF: begin
                    ctrl <= 3'b000;
                    done <= 1'b0;
                end
                S_V_CLR: vrst <= 1'b0;
                S_V_CNT: begin
                    bias_cnt <= CNT_W'(1);
                    lock_cnt <= '0;
                end
                S_V_SET: vote_on <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 100,
    parameter int unsigned BYP_US     = 10,
    parameter int unsigned LOCK_US    = 50,
    parameter logic [5:0]  LOCK_INIT  = 6'd16,
    parameter logic [5:0]  BIAS_INIT  = 6'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_req,
    input  logic        dis_req,
    input  logic        vote_req,
    output logic        pll_outen,
    output logic        pll_bypass_rel,
    output logic        pll_reset_n,
    output logic [21:0] mode_word,
    output logic        done
);

    localparam int unsigned BYP_CYC  = CYC_PER_US * BYP_US;
    localparam int unsigned LOCK_CYC = CYC_PER_US * LOCK_US;
    localparam int unsigned MAX_CYC  = (BYP_CYC > LOCK_CYC) ? BYP_CYC : LOCK_CYC;
    localparam int unsigned TW       = $clog2(MAX_CYC + 1);

    logic             en_pend, dis_pend, vote_pend;
    logic             take_en, take_dis, take_vote;
    logic             tmr_load, tmr_expired;
    logic [TW-1:0]    tmr_val;
    logic [2:0]       ctrl;
    logic [CNT_W-1:0] lock_cnt, bias_cnt;
    logic             vote_on, vrst;

    pll_seq_req u_req (
        .clk        (clk),
        .rst        (rst),
        .en_req     (en_req),
        .dis_req    (dis_req),
        .vote_req   (vote_req),
        .vote_active(vote_on),
        .take_en    (take_en),
        .take_dis   (take_dis),
        .take_vote  (take_vote),
        .en_pend    (en_pend),
        .dis_pend   (dis_pend),
        .vote_pend  (vote_pend)
    );

    pll_seq_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    pll_seq_fsm #(
        .BYP_CYC  (BYP_CYC),
        .LOCK_CYC (LOCK_CYC),
        .TW       (TW),
        .LOCK_INIT(LOCK_INIT),
        .BIAS_INIT(BIAS_INIT)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en_pend    (en_pend),
        .dis_pend   (dis_pend),
        .vote_pend  (vote_pend),
        .tmr_expired(tmr_expired),
        .take_en    (take_en),
        .take_dis   (take_dis),
        .take_vote  (take_vote),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .ctrl       (ctrl),
        .done       (done),
        .lock_cnt   (lock_cnt),
        .bias_cnt   (bias_cnt),
        .vote_on    (vote_on),
        .vrst       (vrst)
    );

    assign pll_outen      = ctrl[C_OUTEN];
    assign pll_bypass_rel = ctrl[C_BYPASS];
    assign pll_reset_n    = ctrl[C_RSTN];
    assign mode_word      = pack_image(ctrl, lock_cnt, bias_cnt, vote_on, vrst);

endmodule

// File: rtl/pll_seq_ctrl_chk.sv
module pll_seq_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic outen,
    input logic byp,
    input logic rstn,
    input logic done,
    input logic vote,
    input logic vrst
);

    // R2
    rstn_after_byp_chk: assert property (@(posedge clk) disable iff (rst)
        rstn |-> byp);

    // R2
    outen_after_rstn_chk: assert property (@(posedge clk) disable iff (rst)
        outen |-> rstn);

    // R4
    done_with_outen_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> outen);

    // R6
    off_together_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(outen) |-> (!byp && !rstn && !done));

    // R8
    vote_after_vrst_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vote) |-> !vrst);

    // R9
    vote_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        vote |=> vote);

    // R9
    vote_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (vote && $past(vote)) |-> $stable({outen, byp, rstn}));

endmodule

bind pll_seq_ctrl pll_seq_ctrl_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .outen(pll_outen),
    .byp  (pll_bypass_rel),
    .rstn (pll_reset_n),
    .done (done),
    .vote (mode_word[20]),
    .vrst (mode_word[21])
);

// File: tb/pll_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pll_seq_ctrl_tb;

    localparam int unsigned CPU  = 2;
    localparam int unsigned BUS  = 10;
    localparam int unsigned LUS  = 50;
    localparam int          BCYC = CPU * BUS;
    localparam int          LCYC = CPU * LUS;
    localparam int          SETTLE = BCYC + LCYC + 10;
    localparam logic [5:0]  LINIT = 6'd16;
    localparam logic [5:0]  BINIT = 6'd0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_req = 1'b0, dis_req = 1'b0, vote_req = 1'b0;
    logic        pll_outen, pll_bypass_rel, pll_reset_n, done;
    logic [21:0] mode_word;

    int n_chk = 0, n_err = 0, cyc = 0;
    int t_byp = 0, t_rst = 0, byp_rises = 0, outen_rises = 0;
    logic p_byp = 1'b0, p_rstn = 1'b0, p_outen = 1'b0;

    always #2.5 clk = ~clk;

    pll_seq_ctrl #(
        .CYC_PER_US(CPU), .BYP_US(BUS), .LOCK_US(LUS),
        .LOCK_INIT(LINIT), .BIAS_INIT(BINIT)
    ) u_dut (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
        .vote_req(vote_req), .pll_outen(pll_outen),
        .pll_bypass_rel(pll_bypass_rel), .pll_reset_n(pll_reset_n),
        .mode_word(mode_word), .done(done)
    );

    function automatic logic [21:0] exp_init();
        logic [21:0] w;
        w = '0;
        w[21] = 1'b1;
        w[13:8] = LINIT;
        w[19:14] = BINIT;
        return w;
    endfunction

    function automatic int exp_ctrl(input bit on);
        return on ? 7 : 0;
    endfunction

    function automatic int ctrl_now();
        return int'({pll_reset_n, pll_bypass_rel, pll_outen});
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit e, input bit d, input bit v);
        @(negedge clk);
        en_req = e; dis_req = d; vote_req = v;
        @(negedge clk);
        en_req = 1'b0; dis_req = 1'b0; vote_req = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(3);
        chk(ctrl_now() == 0 && !done, "R1 ctrl/done", ctrl_now(), 0);
        chk(mode_word == exp_init(), "R1 image", int'(mode_word), int'(exp_init()));
        rst = 1'b0;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // edge-interval monitor (R3, R4)
    always @(negedge clk) begin
        if (rst) begin
            p_byp = 1'b0; p_rstn = 1'b0; p_outen = 1'b0;
        end else begin
            if (pll_bypass_rel && !p_byp) begin
                t_byp = cyc;
                byp_rises++;
            end
            if (pll_reset_n && !p_rstn) begin
                t_rst = cyc;
                chk(cyc - t_byp == BCYC, "R3 bypass-to-reset gap", cyc - t_byp, BCYC);
            end
            if (pll_outen && !p_outen) begin
                outen_rises++;
                chk(cyc - t_rst == LCYC, "R4 reset-to-output gap", cyc - t_rst, LCYC);
                chk(done, "R4 done with output", int'(done), 1);
            end
            p_byp = pll_bypass_rel; p_rstn = pll_reset_n; p_outen = pll_outen;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WATCHDOG", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int r0;
        bit exp_on;
        int unsigned dummy;
        dummy = $urandom(32'h5eed);

        do_reset();

        // R10 latency and R2 first step
        @(negedge clk);
        en_req = 1'b1;
        @(negedge clk);
        en_req = 1'b0;
        chk(!pll_bypass_rel, "R10 no change one edge after sample", int'(pll_bypass_rel), 0);
        @(negedge clk);
        chk(pll_bypass_rel && !pll_reset_n && !pll_outen, "R10/R2 bypass first", ctrl_now(), 2);
        wait_cyc(SETTLE);
        chk(ctrl_now() == 7 && done, "R4 fully on", ctrl_now(), 7);

        // R5 enable while on
        r0 = byp_rises;
        pulse(1, 0, 0);
        wait_cyc(30);
        chk(byp_rises == r0 && ctrl_now() == 7, "R5 enable when on", byp_rises - r0, 0);

        // R6 disable clears together
        @(negedge clk);
        dis_req = 1'b1;
        @(negedge clk);
        dis_req = 1'b0;
        chk(ctrl_now() == 7, "R6 still on before action edge", ctrl_now(), 7);
        @(negedge clk);
        chk(ctrl_now() == 0 && !done, "R6 all cleared at once", ctrl_now(), 0);

        // R7 held disable during sequence
        r0 = outen_rises;
        pulse(1, 0, 0);
        wait_cyc(5);
        pulse(0, 1, 0);
        wait_cyc(SETTLE);
        chk(outen_rises == r0 + 1, "R7 sequence completed", outen_rises - r0, 1);
        chk(ctrl_now() == 0 && !done, "R7 held disable applied", ctrl_now(), 0);

        // R7 same-cycle tie -> disable
        r0 = byp_rises;
        pulse(1, 1, 0);
        wait_cyc(SETTLE);
        chk(ctrl_now() == 0 && byp_rises == r0, "R7 tie resolves to disable", ctrl_now(), 0);

        // random traffic, R7 latest wins
        exp_on = 1'b0;
        for (int i = 0; i < 40; i++) begin
            int op, gap;
            op  = int'($urandom % 4);
            gap = 1 + int'($urandom % 300);
            if (op == 1) begin pulse(1, 0, 0); exp_on = 1'b1; end
            else if (op == 2) begin pulse(0, 1, 0); exp_on = 1'b0; end
            else if (op == 3) begin pulse(1, 1, 0); exp_on = 1'b0; end
            wait_cyc(gap);
            if (gap >= 2 * SETTLE)
                chk(ctrl_now() == exp_ctrl(exp_on), "R7 random settle", ctrl_now(), exp_ctrl(exp_on));
        end
        wait_cyc(2 * SETTLE);
        chk(ctrl_now() == exp_ctrl(exp_on) && done == exp_on, "R7 random final",
            ctrl_now(), exp_ctrl(exp_on));

        // R8 vote entry from off
        do_reset();
        @(negedge clk);
        vote_req = 1'b1;
        @(negedge clk);
        vote_req = 1'b0;
        chk(mode_word[21] == 1'b1, "R8 vrst before entry", int'(mode_word[21]), 1);
        @(negedge clk);
        chk(!mode_word[21] && mode_word[19:14] == BINIT && !mode_word[20],
            "R8 step1 vrst cleared only", int'(mode_word), 0);
        @(negedge clk);
        chk(mode_word[19:14] == 6'd1 && mode_word[13:8] == 6'd0 && !mode_word[20],
            "R8 step2 counts", int'(mode_word[19:8]), 64);
        @(negedge clk);
        chk(mode_word[20], "R8 step3 vote set", int'(mode_word[20]), 1);

        // R9 enable ignored in vote mode
        r0 = byp_rises;
        pulse(1, 0, 0);
        wait_cyc(SETTLE);
        chk(ctrl_now() == 0 && byp_rises == r0, "R9 enable ignored", ctrl_now(), 0);

        // R9 disable ignored in vote mode while on
        do_reset();
        pulse(1, 0, 0);
        wait_cyc(SETTLE);
        pulse(0, 0, 1);
        wait_cyc(8);
        chk(mode_word[20] && ctrl_now() == 7, "R9 vote entered while on", ctrl_now(), 7);
        pulse(0, 1, 0);
        wait_cyc(20);
        chk(ctrl_now() == 7 && done, "R9 disable ignored", ctrl_now(), 7);
        chk(mode_word[20], "R9 vote bit held", int'(mode_word[20]), 1);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule